// File: doc/BRIEF.md
# Per-Set Evicted-Tag History Conflict Detector

This block watches the miss traffic of a set-associative tag store and marks which misses are likely conflict misses. For every set it keeps a short circular history of the tags most recently evicted from that set. A miss whose tag is still present in the history of its own set is reported as a conflict. A saturating counter totals the conflicts reported since reset. The block only observes events. The tag array and the replacement choice belong to the cache.

Each miss event gives the set index and the missing tag. When a line was replaced to make room, the event also carries the victim tag and a flag that marks it as valid. Events arrive on a valid/ready stream. The block never applies back-pressure: `ev_ready` is low only while reset is asserted, and it rises on the first clock edge after reset is released. An event counts only on a cycle where `ev_valid` and `ev_ready` are both high. The result leaves on a one-cycle `res_valid` pulse that carries no ready signal, so a consumer must take it in the cycle it appears.

Top module: `evtag_conflict_det`

## Requirements
- R1: While `rst_n` is low, `ev_ready`, `res_valid` and `res_conflict` are 0, `conflict_count` is 0, and every history entry is invalid. `ev_ready` is 1 from the first rising edge after reset is released.
- R2: An accepted event produces `res_valid`=1 exactly one cycle later. `res_conflict`=1 in that cycle if and only if the missing tag matched a valid history entry of the addressed set.
- R3: Histories are private to each set. A tag evicted from one set never flags a miss to a different set.
- R4: Each set holds the last 2*WAYS victim tags. Pushing a victim into a full history discards the oldest entry, so the tag pushed 2*WAYS+1 pushes earlier no longer matches, while the tag pushed 2*WAYS pushes earlier still does.
- R5: A matched history entry is invalidated, so one eviction yields at most one conflict report. A second miss to the same tag without a new eviction is not a conflict.
- R6: An event with `ev_vic_valid`=0 (a fill into an empty way) pushes nothing into the history.
- R7: The match uses the history as it stood before the event. A miss whose tag equals its own victim tag is not a conflict, but a later miss to that tag in that set is one.
- R8: `conflict_count` increments by one in the cycle `res_conflict` is 1, holds otherwise, and saturates at all ones.
- R9: A cycle with `ev_valid`=0 changes no history and gives `res_valid`=0.
- R10: After reset is released, `ev_ready` stays at 1. `res_conflict` is 1 only when `res_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Miss event present |
| ev_ready | output | 1 | Event accepted (high except during reset) |
| ev_set | input | IDX_W | Set index of the miss |
| ev_tag | input | TAG_W | Tag of the missing line |
| ev_vic_valid | input | 1 | A valid line was replaced |
| ev_vic_tag | input | TAG_W | Tag of the replaced line |
| res_valid | output | 1 | Result pulse, one cycle after acceptance |
| res_conflict | output | 1 | The miss is a conflict |
| conflict_count | output | CNT_W | Saturating count of conflicts |

## Verification
On every cycle the assertions check the stream timing: an accepted event gives a result one cycle later, an idle cycle gives none, and the ready signal never drops after reset. They also check that a conflict flag never appears without `res_valid`, and that the counter steps by exactly one for each conflict and otherwise holds. Whether a given miss should be flagged depends on the history contents, and only the bench's scenarios show that. Those scenarios cover set isolation, the discard of the oldest entry at depth 2*WAYS, invalidation after a match, events with no victim, and the rule that a same-cycle push is not matched. The bench also shows that the counter saturates.

// File: rtl/evtag_pkg.sv
package evtag_pkg;
  // History depth is this multiple of the associativity.
  localparam int unsigned HIST_PER_WAY = 2;
endpackage

// File: rtl/evtag_set_bank.sv
module evtag_set_bank #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             push_en,
  input  logic [TAG_W-1:0] push_tag,
  output logic             hit
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] wp_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match[i] = vld_q[i] && (tag_q[i] == lk_tag);
  end
  assign hit = |match;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
      end else if (push_en && wp_q == PTR_W'(e)) begin
        vld_q[e] <= 1'b1;
        tag_q[e] <= push_tag;
      end else if (lk_en && match[e]) begin
        vld_q[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wp_q <= '0;
    else if (push_en)
      wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
  end
endmodule

// File: rtl/evtag_sat_counter.sv
module evtag_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (inc && count != {W{1'b1}})
      count <= count + W'(1);
  end
endmodule

// File: rtl/evtag_conflict_det.sv
module evtag_conflict_det #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [IDX_W-1:0] ev_set,
  input  logic [TAG_W-1:0] ev_tag,
  input  logic             ev_vic_valid,
  input  logic [TAG_W-1:0] ev_vic_tag,
  output logic             res_valid,
  output logic             res_conflict,
  output logic [CNT_W-1:0] conflict_count
);
  localparam int unsigned DEPTH = evtag_pkg::HIST_PER_WAY * WAYS;

  logic            acc;
  logic [SETS-1:0] hit_vec;
  logic            hit;

  assign acc = ev_valid && ev_ready;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = acc && (ev_set == IDX_W'(s));
    evtag_set_bank #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (sel),
      .lk_tag   (ev_tag),
      .push_en  (sel && ev_vic_valid),
      .push_tag (ev_vic_tag),
      .hit      (hit_vec[s])
    );
  end

  assign hit = hit_vec[ev_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_ready     <= 1'b0;
      res_valid    <= 1'b0;
      res_conflict <= 1'b0;
    end else begin
      ev_ready     <= 1'b1;
      res_valid    <= acc;
      res_conflict <= acc && hit;
    end
  end

  evtag_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (acc && hit),
    .count (conflict_count)
  );
endmodule

// File: rtl/evtag_conflict_det_chk.sv
module evtag_conflict_det_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [IDX_W-1:0] ev_set,
  input logic [TAG_W-1:0] ev_tag,
  input logic             ev_vic_valid,
  input logic [TAG_W-1:0] ev_vic_tag,
  input logic             res_valid,
  input logic             res_conflict,
  input logic [CNT_W-1:0] conflict_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> res_valid);

  // R9
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_ready) |=> !res_valid);

  // R10
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> ev_ready);

  // R10
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_conflict |-> res_valid);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_conflict && $past(conflict_count) != CMAX) |->
      conflict_count == $past(conflict_count) + CNT_W'(1));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_conflict |-> $stable(conflict_count));
endmodule

bind evtag_conflict_det evtag_conflict_det_chk #(
  .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_set(ev_set), .ev_tag(ev_tag), .ev_vic_valid(ev_vic_valid),
  .ev_vic_tag(ev_vic_tag), .res_valid(res_valid),
  .res_conflict(res_conflict), .conflict_count(conflict_count)
);

// File: tb/test_evtag_conflict_det.sv
`timescale 1ns/1ps
module test_evtag_conflict_det;
  localparam int unsigned SETS = 8, WAYS = 2, TAG_W = 8, CNT_W = 6;
  localparam int unsigned IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_vic_valid = 1'b0;
  logic [IDX_W-1:0] ev_set = '0;
  logic [TAG_W-1:0] ev_tag = '0, ev_vic_tag = '0;
  logic ev_ready, res_valid, res_conflict;
  logic [CNT_W-1:0] conflict_count;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evtag_conflict_det #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W))
  i_evtag_conflict_det (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_set(ev_set), .ev_tag(ev_tag), .ev_vic_valid(ev_vic_valid),
    .ev_vic_tag(ev_vic_tag), .res_valid(res_valid),
    .res_conflict(res_conflict), .conflict_count(conflict_count)
  );

  typedef struct packed {
    logic [2:0] set;
    logic [7:0] tag;
    logic       vv;
    logic [7:0] vtag;
    logic       exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 8'h10, 1'b1, 8'h20, 1'b0},  // R2 first eviction
    '{3'd1, 8'h20, 1'b1, 8'h30, 1'b1},  // R2 hit on 20
    '{3'd1, 8'h20, 1'b0, 8'h00, 1'b0},  // R5 entry cleared
    '{3'd2, 8'h30, 1'b0, 8'h00, 1'b0},  // R3 other set
    '{3'd2, 8'h40, 1'b0, 8'h55, 1'b0},  // R6 no victim
    '{3'd2, 8'h55, 1'b0, 8'h00, 1'b0},  // R6 nothing pushed
    '{3'd3, 8'h66, 1'b1, 8'h66, 1'b0},  // R7 own victim
    '{3'd3, 8'h66, 1'b0, 8'h00, 1'b1},  // R7 later hit
    '{3'd4, 8'h01, 1'b1, 8'hA1, 1'b0},  // R4 fill
    '{3'd4, 8'h02, 1'b1, 8'hA2, 1'b0},
    '{3'd4, 8'h03, 1'b1, 8'hA3, 1'b0},
    '{3'd4, 8'h04, 1'b1, 8'hA4, 1'b0},
    '{3'd4, 8'h05, 1'b1, 8'hA5, 1'b0},  // R4 discards A1
    '{3'd4, 8'hA1, 1'b0, 8'h00, 1'b0},  // R4 oldest gone
    '{3'd4, 8'hA2, 1'b0, 8'h00, 1'b1},  // R4 depth-th still held
    '{3'd1, 8'h30, 1'b0, 8'h00, 1'b1}   // R3 own set still hits
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] s, input logic [7:0] t,
                      input logic v, input logic [7:0] vt);
    ev_valid = 1'b1; ev_set = s; ev_tag = t; ev_vic_valid = v; ev_vic_tag = vt;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", ev_ready, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 count", conflict_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", ev_ready, 1);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].set, VECS[i].tag, VECS[i].vv, VECS[i].vtag);
      chk("R2 res_valid", res_valid, 1);
      chk($sformatf("R2 conflict vec %0d", i), res_conflict, VECS[i].exp);
    end
    chk("R8 count after table", conflict_count, 4);

    // R9: idle cycle with a matching tag on the bus changes nothing
    send(3'd5, 8'h11, 1'b1, 8'hB1);
    ev_set = 3'd5; ev_tag = 8'hB1; ev_vic_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle res_valid", res_valid, 0);
    chk("R9 idle count", conflict_count, 4);
    send(3'd5, 8'hB1, 1'b0, 8'h00);
    chk("R9 history kept", res_conflict, 1);
    chk("R10 ready held", ev_ready, 1);

    // R8 saturation: alternating tags in set 6 conflict every event after the first
    for (int k = 0; k < 70; k++)
      send(3'd6, (k % 2) ? 8'hC1 : 8'hC0, 1'b1, (k % 2) ? 8'hC0 : 8'hC1);
    chk("R8 last still conflict", res_conflict, 1);
    chk("R8 saturated", conflict_count, 63);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule